// File: doc/BRIEF.md
# Register-Access Serial Slave with Wrapping Auto-Increment

This block is a serial-peripheral slave for a small byte-wide register file. The bus runs in mode 0: the clock idles low, and both sides sample on the rising clock edge. The block shifts data out on the falling edge, most significant bit first.

Every frame opens with a command byte. Its top bit picks the direction and its low seven bits give the starting register. Data bytes follow for as long as chip select stays low and the serial clock keeps toggling. After each data byte, the working address moves to the next slot. Past the last real register the sequence passes through a few empty slots and then returns to slot zero.

The serial clock, chip select and input data are sampled in the system clock domain through synchronizer stages. The serial clock must therefore be slow compared with the system clock. The serial output comes out as a data bit plus an enable, and the pad's three-state buffer sits outside the block.

Top module: `spi_regfile_slave`

## Requirements
- R1: Frames use mode 0, most significant bit first. In the first byte of a frame, bit 7 = 1 requests a read and bit 7 = 0 requests a write. Bits 6:0 of that byte give the start address.
- R2: In a write frame, each data byte is stored in the register at the working address when the byte's eighth rising clock edge arrives. A later read returns that value.
- R3: In a read frame, the value at the working address is placed on `miso` at the falling clock edge after the byte's eighth rising edge. The enable `miso_oe` is asserted at the same time. The remaining bits follow on the next falling edges, most significant bit first.
- R4: Addresses from NUM_REGS (5) upward are empty slots. They read back as 0x00, and writes to them change no register.
- R5: Each completed data byte advances the working address by one. From address NUM_REGS+NUM_DUMMY-1 (7), or from any address above it, the next address is 0x00.
- R6: `miso_oe` is low in four cases: while chip select is high, during the command byte, throughout write frames, and out of reset.
- R7: If chip select rises before a byte is complete, that byte has no effect. The next frame starts again with a command byte.
- R8: Reset clears all registers to 0x00.
- R9: The block works with a serial clock half period of 4 system clock cycles or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Drive enable for the external miso pad buffer |

## Verification
The bench writes and reads bursts of eleven bytes from every start address 0 to 7. Each burst crosses the empty slots and the wrap back to zero. A design that wrapped too early, too late or into the empty slots would send later bytes to the wrong register, and read-back would show it.

A start address far above 7 checks that the address returns to zero rather than running on upward. Chip select is raised mid-byte in both the command byte and a data byte. A design that kept a partial bit count, or committed the half byte, would corrupt a register or misread the next frame.

One read pass runs at the minimum half period. This exposes a first read bit that is loaded too late.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              sck_prev;
        logic              cs_prev;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-2:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [ADDR_W-1:0] addr;
        phase_e            phase;
        logic              is_read;
        logic              load_pend;
        logic              oe;
    } eng_s;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rf_store.sv
module spi_rf_store
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_d;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    // R4: a write aimed at an empty slot leaves every register untouched
    a_r4_dummy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(regs_q));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS    = 5,
    parameter int NUM_DUMMY   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    localparam int WRAP_AT = NUM_REGS + NUM_DUMMY;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WRAP_AT - 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W - 1);

    logic [2:0] pins_s;
    logic       cs_s, sck_s, mosi_s;

    spi_rf_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sck, mosi}),
        .sync_o  (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    eng_s q, d;
    logic              sck_rise, sck_fall;
    logic [BYTE_W-1:0] rx_byte;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return (a >= LAST_ADDR) ? '0 : a + 1'b1;
    endfunction

    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;
    assign rx_byte  = {q.rx, mosi_s};

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        d.cs_prev  = cs_s;
        wr_en      = 1'b0;
        if (cs_s) begin
            d.bit_cnt   = '0;
            d.phase     = PH_CMD;
            d.is_read   = 1'b0;
            d.load_pend = 1'b0;
            d.oe        = 1'b0;
        end else if (sck_rise) begin
            d.rx      = rx_byte[BYTE_W-2:0];
            d.bit_cnt = q.bit_cnt + 1'b1;
            if (q.bit_cnt == LAST_BIT) begin
                if (q.phase == PH_CMD) begin
                    d.phase     = PH_DATA;
                    d.is_read   = rx_byte[BYTE_W-1];
                    d.addr      = rx_byte[ADDR_W-1:0];
                    d.load_pend = rx_byte[BYTE_W-1];
                end else begin
                    wr_en       = ~q.is_read;
                    d.addr      = step_addr(q.addr);
                    d.load_pend = q.is_read;
                end
            end
        end else if (sck_fall) begin
            if (q.load_pend) begin
                d.tx        = rd_data;
                d.oe        = 1'b1;
                d.load_pend = 1'b0;
            end else if (q.oe) begin
                d.tx = {q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    spi_rf_store #(
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (q.addr),
        .wr_data (rx_byte),
        .rd_addr (q.addr),
        .rd_data (rd_data)
    );

    assign miso    = q.tx[BYTE_W-1];
    assign miso_oe = q.oe;

    // R6: deselect releases the output
    a_r6_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe);

    // R6: output only ever driven inside a read frame
    a_r6_drive_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> q.is_read);

    // R7: deselect mid-byte clears the bit position
    a_r7_abort_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !q.cs_prev) |=> (q.bit_cnt == '0 && q.phase == PH_CMD));

    // R5: the last slot is followed by slot zero
    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && sck_rise && q.phase == PH_DATA && q.bit_cnt == LAST_BIT
         && q.addr == LAST_ADDR) |=> (q.addr == '0));

    // R4: a load from an empty slot puts zero on the line
    a_r4_dummy_loads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && sck_fall && q.load_pend && q.addr >= ADDR_W'(NUM_REGS))
        |=> (q.tx == '0 && miso_oe));
endmodule

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
    localparam int CLK_P = 10;
    localparam int NREG  = 5;
    localparam int WRAP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int checks = 0;
    int errors = 0;
    int half = 6;
    bit finished = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] tx_buf [32];
    logic [7:0] rx_buf [32];

    always #(CLK_P/2) clk = ~clk;

    spi_regfile_slave u_spi_regfile_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nxt(input int a);
        return (a >= WRAP - 1) ? 0 : a + 1;
    endfunction

    function automatic logic [7:0] expect_rd(input int a);
        return (a < NREG) ? model[a] : 8'h00;
    endfunction

    task automatic spi_bits(input logic [7:0] out, input int nb,
                            output logic [7:0] inb, output bit drove);
        inb = '0;
        drove = 1'b0;
        for (int b = 7; b >= 8 - nb; b--) begin
            mosi = out[b];
            repeat (half) @(negedge clk);
            inb[b] = miso;
            if (miso_oe) drove = 1'b1;
            sck = 1'b1;
            repeat (half) @(negedge clk);
            if (miso_oe) drove = 1'b1;
            sck = 1'b0;
        end
    endtask

    task automatic do_frame(input bit rd, input int a, input int n);
        logic [7:0] r;
        bit drv;
        cs_n = 1'b0;
        repeat (half) @(negedge clk);
        spi_bits({rd, 7'(a)}, 8, r, drv);
        chk(!drv, "R6 command byte not driven", int'(drv), 0);
        for (int k = 0; k < n; k++) begin
            spi_bits(tx_buf[k], 8, r, drv);
            rx_buf[k] = r;
            if (rd) chk(drv, "R3 read byte driven", int'(drv), 1);
            else    chk(!drv, "R6 write byte not driven", int'(drv), 0);
        end
        repeat (half) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * half) @(negedge clk);
        chk(!miso_oe, "R6 released after deselect", int'(miso_oe), 0);
    endtask

    task automatic burst_write(input int s, input int n, input int seed);
        int a = s;
        for (int k = 0; k < n; k++) begin
            tx_buf[k] = 8'((seed * 16 + k * 37 + 11) & 8'hFF);
            if (a < NREG) model[a] = tx_buf[k];
            a = nxt(a);
        end
        do_frame(1'b0, s, n);
    endtask

    task automatic burst_read_check(input int s, input int n);
        int a = s;
        for (int k = 0; k < n; k++) tx_buf[k] = 8'h00;
        do_frame(1'b1, s, n);
        for (int k = 0; k < n; k++) begin
            if (a >= NREG)
                chk(rx_buf[k] == 8'h00, "R4 empty slot reads zero", rx_buf[k], 0);
            else
                chk(rx_buf[k] == expect_rd(a), "R5 burst address order", rx_buf[k], expect_rd(a));
            a = nxt(a);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        bit drv;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(!miso_oe, "R6 released in reset", int'(miso_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: all registers start at zero
        for (int i = 0; i < NREG; i++) begin
            tx_buf[0] = 8'h00;
            do_frame(1'b1, i, 1);
            chk(rx_buf[0] == 8'h00, "R8 reset value", rx_buf[0], 0);
        end

        // R1/R2/R3: single-byte frames per register
        for (int i = 0; i < NREG; i++) begin
            tx_buf[0] = 8'(8'hA5 ^ (i * 37));
            model[i] = tx_buf[0];
            do_frame(1'b0, i, 1);
        end
        for (int i = 0; i < NREG; i++) begin
            tx_buf[0] = 8'h00;
            do_frame(1'b1, i, 1);
            chk(rx_buf[0] == model[i], "R1 R2 R3 single read", rx_buf[0], model[i]);
        end

        // R5/R4: burst from every start address across the wrap
        for (int s = 0; s < WRAP; s++) begin
            burst_write(s, 11, s + 1);
            burst_read_check(s, 11);
        end

        // R5: start far above the last slot wraps to zero
        burst_write(8'h55, 4, 9);
        burst_read_check(0, NREG);

        // R7: deselect during a data byte
        cs_n = 1'b0;
        repeat (half) @(negedge clk);
        spi_bits(8'h02, 8, r, drv);
        spi_bits(8'h3C, 4, r, drv);
        repeat (half) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * half) @(negedge clk);
        tx_buf[0] = 8'h00;
        do_frame(1'b1, 2, 1);
        chk(rx_buf[0] == model[2], "R7 partial data byte dropped", rx_buf[0], model[2]);

        // R7: deselect during the command byte, then a clean frame
        cs_n = 1'b0;
        repeat (half) @(negedge clk);
        spi_bits(8'h81, 3, r, drv);
        repeat (half) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * half) @(negedge clk);
        tx_buf[0] = 8'h00;
        do_frame(1'b1, 1, 1);
        chk(rx_buf[0] == model[1], "R7 fresh frame after abort", rx_buf[0], model[1]);

        // R9: minimum half period
        half = 4;
        burst_write(3, 9, 5);
        begin
            int a = 3;
            for (int k = 0; k < 9; k++) tx_buf[k] = 8'h00;
            do_frame(1'b1, 3, 9);
            for (int k = 0; k < 9; k++) begin
                chk(rx_buf[k] == expect_rd(a), "R9 fast clock read", rx_buf[k], expect_rd(a));
                a = nxt(a);
            end
        end

        finish_run();
    end
endmodule